// File: doc/BRIEF.md
# Processing Element Mask Stack

Each element of an associative processing array holds a one-bit activity stack and a one-bit responder register. The top stack entry says whether the element is active. An instruction marked as masked runs in the element only while that top bit is 1. An unmasked instruction runs in the element whatever the stack holds. The stack nests up to sixteen levels of association. Because of this, a search can narrow the active set, work on it, and then restore the outer set by popping.

A search result lands in the responder register through a load port. The control unit then issues stack operations over a 3-bit operation code. The operations are:
- set the top to 1;
- push the AND of the responder and the top, writing the same bit back into the responder;
- push the responder unchanged;
- overwrite the top with the responder;
- pop;
- pop and copy the uncovered entry into the responder.

A push at full depth or a pop at depth one leaves everything as it was and raises an error flag. The flag stays set until reset.

Top module: `pe_mask_stack`

## Requirements
- R1: After reset the depth is 1, the top is 1, the responder is 0, the error flag is 0 and the execute enable is 1.
- R2: When `masked` is 0, `exec_en` is 1 whatever the stack holds.
- R3: When `masked` is 1, `exec_en` equals the top entry.
- R4: Code 1 (set) forces the top entry to 1 and leaves the depth unchanged.
- R5: Code 2 (AND-push) pushes responder AND top, writes that same bit into the responder, and raises the depth by one.
- R6: Code 6 (plain push) pushes the responder bit, raises the depth by one, and leaves the responder unchanged.
- R7: Code 3 (pop) discards the top, lowers the depth by one, and the entry below becomes the top. The responder is not changed.
- R8: Code 5 (pop to responder) pops like code 3 and loads the uncovered new top into the responder.
- R9: Code 4 (replace) writes the responder into the top entry and leaves the depth unchanged.
- R10: Code 2 or 6 at full depth sets the error flag and leaves depth, entries and responder unchanged by the operation.
- R11: Code 3 or 5 at depth 1 sets the error flag and leaves depth, entries and responder unchanged by the operation.
- R12: The error flag stays 1 until reset. Codes 0 and 7 change nothing.
- R13: `resp_load` writes `resp_in` into the responder, unless an operation that writes the responder succeeds in the same cycle; in that case the operation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Stack operation strobe |
| op_code | input | 3 | Stack operation code |
| resp_load | input | 1 | Load strobe for the responder register |
| resp_in | input | 1 | Search result to load |
| masked | input | 1 | Current instruction is masked |
| exec_en | output | 1 | Element executes the current instruction |
| top_bit | output | 1 | Top entry of the stack |
| resp_q | output | 1 | Responder register |
| depth | output | $clog2(DEPTH+1) | Number of valid entries |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Assertions check the following on every cycle:
- the depth bounds;
- the gating of execution by the masked flag;
- the one-step depth changes and the value written on a push;
- the forcing of the top by the set operation;
- the freeze of depth on overflow and underflow;
- the stickiness of the error flag.

Some behaviours show only in the bench's sequences:
- that entries pushed earlier come back in the right order several pops later;
- that the AND-push narrows the active set;
- the priority between an operation and a same-cycle responder load;
- the fill to exactly sixteen levels.

// File: rtl/pe_mask_pkg.sv
package pe_mask_pkg;

  typedef enum logic [2:0] {
    MOP_NOP       = 3'd0,
    MOP_SET       = 3'd1,
    MOP_PUSH_AND  = 3'd2,
    MOP_POP       = 3'd3,
    MOP_REPLACE   = 3'd4,
    MOP_POP_RESP  = 3'd5,
    MOP_PUSH_RESP = 3'd6,
    MOP_RSVD      = 3'd7
  } mask_op_e;

  // Bit pushed by the AND-push: responder narrowed by current activity.
  function automatic logic narrow_bit(input logic resp, input logic top);
    return resp & top;
  endfunction

  // Execution gate: unmasked always runs, masked runs when active.
  function automatic logic gate_exec(input logic is_masked, input logic top);
    return (!is_masked) | top;
  endfunction

endpackage

// File: rtl/mask_op_ctrl.sv
module mask_op_ctrl
  import pe_mask_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] depth,
  input  logic          top,
  input  logic          below,
  input  logic          resp,
  output logic          push_en,
  output logic          pop_en,
  output logic          wr_top_en,
  output logic          din,
  output logic          resp_wr_en,
  output logic          resp_wr_val,
  output logic          over_evt,
  output logic          under_evt
);

  mask_op_e op;
  logic     is_full;
  logic     is_single;

  always_comb begin
    op          = mask_op_e'(op_code);
    is_full     = (depth == DW'(DEPTH));
    is_single   = (depth == DW'(1));
    push_en     = 1'b0;
    pop_en      = 1'b0;
    wr_top_en   = 1'b0;
    din         = 1'b0;
    resp_wr_en  = 1'b0;
    resp_wr_val = 1'b0;
    over_evt    = 1'b0;
    under_evt   = 1'b0;
    if (op_valid) begin
      unique case (op)
        MOP_SET: begin
          wr_top_en = 1'b1;
          din       = 1'b1;
        end
        MOP_REPLACE: begin
          wr_top_en = 1'b1;
          din       = resp;
        end
        MOP_PUSH_AND, MOP_PUSH_RESP: begin
          if (is_full) begin
            over_evt = 1'b1;
          end else begin
            push_en = 1'b1;
            din     = (op == MOP_PUSH_AND) ? narrow_bit(resp, top) : resp;
            if (op == MOP_PUSH_AND) begin
              resp_wr_en  = 1'b1;
              resp_wr_val = narrow_bit(resp, top);
            end
          end
        end
        MOP_POP, MOP_POP_RESP: begin
          if (is_single) begin
            under_evt = 1'b1;
          end else begin
            pop_en = 1'b1;
            if (op == MOP_POP_RESP) begin
              resp_wr_en  = 1'b1;
              resp_wr_val = below;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mask_bit_stack.sv
module mask_bit_stack #(
  parameter int DEPTH = 16,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          wr_top_en,
  input  logic          din,
  output logic          top,
  output logic          below,
  output logic [DW-1:0] depth
);

  // Entry 0 is always the top; pushes shift toward higher indices.
  logic [DEPTH-1:0] stk;
  logic [DW-1:0]    depth_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i == 0) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  stk[i] <= 1'b1;
        else if (push_en || wr_top_en) stk[i] <= din;
        else if (pop_en)             stk[i] <= stk[i+1];
      end
    end else if (i == DEPTH - 1) begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stk[i] <= 1'b0;
        else if (push_en) stk[i] <= stk[i-1];
        else if (pop_en)  stk[i] <= 1'b0;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stk[i] <= 1'b0;
        else if (push_en) stk[i] <= stk[i-1];
        else if (pop_en)  stk[i] <= stk[i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       depth_q <= DW'(1);
    else if (push_en) depth_q <= depth_q + DW'(1);
    else if (pop_en)  depth_q <= depth_q - DW'(1);
  end

  assign top   = stk[0];
  assign below = stk[1];
  assign depth = depth_q;

  assert_depth_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q >= DW'(1)) && (depth_q <= DW'(DEPTH)));

  assert_push_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (depth_q == $past(depth_q) + DW'(1)) && (stk[0] == $past(din)));

  assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> (depth_q == $past(depth_q) - DW'(1)) && (stk[0] == $past(stk[1])));

  assert_no_pop_at_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> depth_q > DW'(1));

endmodule

// File: rtl/pe_mask_stack.sv
module pe_mask_stack
  import pe_mask_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          resp_load,
  input  logic          resp_in,
  input  logic          masked,
  output logic          exec_en,
  output logic          top_bit,
  output logic          resp_q,
  output logic [DW-1:0] depth,
  output logic          stk_err
);

  logic push_en, pop_en, wr_top_en, din;
  logic resp_wr_en, resp_wr_val, over_evt, under_evt;
  logic top, below;
  logic resp_r, err_r;

  mask_op_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .op_valid    (op_valid),
    .op_code     (op_code),
    .depth       (depth),
    .top         (top),
    .below       (below),
    .resp        (resp_r),
    .push_en     (push_en),
    .pop_en      (pop_en),
    .wr_top_en   (wr_top_en),
    .din         (din),
    .resp_wr_en  (resp_wr_en),
    .resp_wr_val (resp_wr_val),
    .over_evt    (over_evt),
    .under_evt   (under_evt)
  );

  mask_bit_stack #(.DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .wr_top_en (wr_top_en),
    .din       (din),
    .top       (top),
    .below     (below),
    .depth     (depth)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resp_r <= 1'b0;
    else if (resp_wr_en) resp_r <= resp_wr_val;
    else if (resp_load)  resp_r <= resp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    err_r <= 1'b0;
    else if (over_evt || under_evt) err_r <= 1'b1;
  end

  assign exec_en = gate_exec(masked, top);
  assign top_bit = top;
  assign resp_q  = resp_r;
  assign stk_err = err_r;

  assert_unmasked_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !masked |-> exec_en);

  assert_masked_follows_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> (exec_en == top_bit));

  assert_set_forces_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1) |=> top_bit && $stable(depth));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt |=> stk_err && $stable(depth) && $stable(top_bit));

  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> stk_err && (depth == DW'(1)) && $stable(top_bit));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

endmodule

// File: tb/pe_mask_stack_test.sv
module pe_mask_stack_test;

  localparam int DEPTH = 16;
  localparam int DW    = $clog2(DEPTH + 1);
  localparam int NV    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic          resp_load = 1'b0;
  logic          resp_in = 1'b0;
  logic          masked = 1'b0;
  logic          exec_en, top_bit, resp_q, stk_err;
  logic [DW-1:0] depth;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pe_mask_stack #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .resp_load(resp_load), .resp_in(resp_in), .masked(masked),
    .exec_en(exec_en), .top_bit(top_bit), .resp_q(resp_q),
    .depth(depth), .stk_err(stk_err)
  );

  // Row: {req[3:0], valid, op[2:0], load, rin, masked, top, resp, depth[4:0], err, exec}
  localparam logic [19:0] VEC [NV] = '{
    {4'd13, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd1, 1'b0, 1'b1}, // R13 load 1
    {4'd5,  1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd2, 1'b0, 1'b1}, // R5 push 1&1
    {4'd13, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd2, 1'b0, 1'b1}, // R13 load 0
    {4'd3,  1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 1'b0, 1'b0}, // R3 push 0&1, masked off
    {4'd2,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b0, 1'b1}, // R2 unmasked runs
    {4'd9,  1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0}, // R9 replace uses old resp
    {4'd9,  1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b1}, // R9 replace with 1
    {4'd6,  1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd4, 1'b0, 1'b1}, // R6 plain push 1
    {4'd13, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd4, 1'b0, 1'b1}, // R13 load 0
    {4'd6,  1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd5, 1'b0, 1'b0}, // R6 plain push 0
    {4'd4,  1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5, 1'b0, 1'b1}, // R4 set top
    {4'd7,  1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd4, 1'b0, 1'b1}, // R7 pop
    {4'd8,  1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3, 1'b0, 1'b1}, // R8 pop to resp beats load
    {4'd7,  1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd2, 1'b0, 1'b1}, // R7 pop
    {4'd7,  1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1, 1'b0, 1'b1}, // R7 pop to bottom
    {4'd11, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1, 1'b1, 1'b1}, // R11 underflow
    {4'd12, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd1, 1'b1, 1'b1}, // R12 nop, err kept
    {4'd12, 1'b1, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1, 1'b1, 1'b1}  // R12 code 7 no effect
  };

  task automatic drive(input logic v, input logic [2:0] op, input logic rl,
                       input logic ri, input logic mk);
    op_valid = v; op_code = op; resp_load = rl; resp_in = ri; masked = mk;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic t, input logic r,
                       input logic [DW-1:0] d, input logic e, input logic x);
    checks++;
    if ({top_bit, resp_q, depth, stk_err, exec_en} !== {t, r, d, e, x}) begin
      fails++;
      $display("FAIL %s: got top=%b resp=%b depth=%0d err=%b exec=%b, expected top=%b resp=%b depth=%0d err=%b exec=%b",
               req, top_bit, resp_q, depth, stk_err, exec_en, t, r, d, e, x);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got no finish, expected finish");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1", 1'b1, 1'b0, DW'(1), 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check($sformatf("R%0d row %0d", VEC[i][19:16], i),
            VEC[i][8], VEC[i][7], DW'(VEC[i][6:2]), VEC[i][1], VEC[i][0]);
    end

    // R1: reset clears the sticky error and restores the single active entry
    do_reset();
    check("R1", 1'b1, 1'b0, DW'(1), 1'b0, 1'b1);

    // R10: fill to full depth with zero-valued AND-pushes, then overflow
    for (int k = 0; k < DEPTH - 1; k++) drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b1);
    check("R5", 1'b0, 1'b0, DW'(DEPTH), 1'b0, 1'b0);
    drive(1'b1, 3'd6, 1'b0, 1'b0, 1'b1);
    check("R10", 1'b0, 1'b0, DW'(DEPTH), 1'b1, 1'b0);
    drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
    check("R10", 1'b0, 1'b0, DW'(DEPTH), 1'b1, 1'b1);
    drive(1'b1, 3'd3, 1'b0, 1'b0, 1'b1);
    check("R12", 1'b0, 1'b0, DW'(DEPTH - 1), 1'b1, 1'b0);
    // R7: drain back to one entry; bottom entry is the reset 1
    for (int k = 0; k < DEPTH - 2; k++) drive(1'b1, 3'd3, 1'b0, 1'b0, 1'b1);
    check("R7", 1'b1, 1'b0, DW'(1), 1'b1, 1'b1);

    // R11: pop-to-responder at depth one leaves the responder alone
    do_reset();
    drive(1'b0, 3'd0, 1'b1, 1'b1, 1'b1);
    drive(1'b1, 3'd5, 1'b0, 1'b0, 1'b1);
    check("R11", 1'b1, 1'b1, DW'(1), 1'b1, 1'b1);
    // R13: a failed operation does not block a same-cycle load
    drive(1'b1, 3'd5, 1'b1, 1'b0, 1'b1);
    check("R13", 1'b1, 1'b0, DW'(1), 1'b1, 1'b1);

    finish_run();
  end

endmodule